// File: doc/BRIEF.md
# Channel Protection Retry Controller

This block guards one output channel of a multi-channel power amplifier. Analog comparators upstream turn the channel's sensed conditions into digital flags. The flags cover three short types, the output voltage against two levels, the load current against two levels, and the current imbalance between the high and low side against two levels. The controller decides from these flags when the power stage must be switched off. It holds the stage off for a fixed cool-down period and then retries it. A short that is still present trips the channel again on the cycle after the retry.

All time is counted in ticks of a prescaled strobe, so the qualification windows and the cool-down are plain tick counts set by parameters. Each kind of fault is handled in its own way:
- Shorts trip the channel at once.
- A high current at low output voltage must persist before it trips the channel.
- A very high current at normal output voltage trips the channel at once.
- A current imbalance trips the channel after a short persistence window, and its threshold depends on the output voltage.

The controller reports a load-fault flag and a code for the kind of fault to the diagnostic logic. A host control input can hold the channel off, which stops all retries.

Top module: `chan_guard`

## Requirements
- R1: With the channel enabled and `host_off` low, any of `short_gnd`, `short_sup` or `short_load` sampled high at a clock edge drives `ch_en` low after that edge.
- R2: After a trip, `ch_en` stays low for exactly `OFF_TICKS` edges on which `tick` is high, and then returns high. Edges with `tick` low do not advance the cool-down.
- R3: If a short is still present when the channel is retried, `ch_en` is high for one cycle and then low again for a new cool-down period.
- R4: Low-voltage overcurrent (`vdiff_lo` and `i_over4` both high) trips the channel only after it has been sampled on `SOA_QUAL_TICKS` consecutive ticked edges, with the trip taking effect on the next edge. Any cycle without the condition restarts the count, and edges without `tick` do not advance it.
- R5: High-voltage overcurrent (`vdiff_lo` low and `i_over8` high) trips the channel at the next edge. `i_over8` together with `vdiff_lo` high has no immediate effect.
- R6: A current imbalance trips the channel after `SPK_QUAL_TICKS` consecutive ticked edges followed by one more edge. The qualifying condition is `imiss_over1` while `vout_lo` is high, or `imiss_over3` while `vout_lo` is low. `imiss_over1` alone with `vout_lo` low never trips the channel.
- R7: `fault_kind` takes the code of each trip and holds it until the next trip. The codes are 1 for a ground short, 2 for a supply short, 3 for a short across the load, 4 for either overcurrent rule, and 5 for a current imbalance. When faults coincide, the priority runs ground, supply, across, overcurrent, imbalance. `load_fault` is high exactly while a cool-down is running.
- R8: `host_off` high drives `ch_en` and `load_fault` low after the next edge, overrides any trip, and stops all retries for as long as it is held. `fault_kind` is unchanged. One edge after `host_off` is released, `ch_en` is high again.
- R9: During and after reset, `ch_en` is 1, `load_fault` is 0 and `fault_kind` is 0.
- R10: Fault flags are ignored during a cool-down. They neither extend it nor change `fault_kind`, and the qualification counts restart from zero once the channel is retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled time strobe, one cycle wide |
| host_off | input | 1 | Host request to hold the channel off |
| short_gnd | input | 1 | Output shorted to ground |
| short_sup | input | 1 | Output shorted to supply |
| short_load | input | 1 | Short across the load |
| vdiff_lo | input | 1 | Differential output below 1 V |
| i_over4 | input | 1 | Load current above 4 A |
| i_over8 | input | 1 | Load current above 8 A |
| imiss_over1 | input | 1 | Side current imbalance above 1 A |
| imiss_over3 | input | 1 | Side current imbalance above 3 A |
| vout_lo | input | 1 | Output below 1.75 V |
| ch_en | output | 1 | Power stage enable |
| load_fault | output | 1 | Cool-down in progress after a fault |
| fault_kind | output | 3 | Code of the most recent trip |

## Verification
Each internal fault has a visible symptom at the ports:
- A stuck or miscounted cool-down counter moves the rising edge of `ch_en` away from its expected cycle, and this shows on the very retry that follows.
- A qualification counter that fails to restart trips the channel early, after a broken run of the condition. A counter that advances without `tick` trips it before the tick-based deadline.
- A state register that misses the host hold shows one edge after `host_off`, as `ch_en` staying high.
- A wrong priority or a lost latch shows in `fault_kind` from the cycle of the trip onward.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_GND    = 3'd1,
    KIND_SUP    = 3'd2,
    KIND_ACROSS = 3'd3,
    KIND_OVERI  = 3'd4,
    KIND_IMBAL  = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_COOL = 2'd1,
    ST_HELD = 2'd2
  } guard_st_e;

  // Imbalance threshold depends on the output level.
  function automatic logic imbal_cond(input logic v_lo, input logic m1, input logic m3);
    return (v_lo && m1) || (!v_lo && m3);
  endfunction

  // Fixed priority: ground, supply, across, overcurrent, imbalance.
  function automatic kind_e pick_kind(input logic g, input logic s, input logic a,
                                      input logic oi, input logic im);
    if (g)  return KIND_GND;
    if (s)  return KIND_SUP;
    if (a)  return KIND_ACROSS;
    if (oi) return KIND_OVERI;
    if (im) return KIND_IMBAL;
    return KIND_NONE;
  endfunction

  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit + 1) : 1;
  endfunction

endpackage

// File: rtl/chan_guard_persist.sv
module chan_guard_persist #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  input  logic cond,
  output logic qualified
);
  import chan_guard_pkg::*;

  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!arm || !cond)    cnt <= '0;
    else if (tick && cnt != CAP) cnt <= cnt + 1'b1;
  end

  assign qualified = arm && cond && (cnt == CAP);

  AST_PERSIST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond || !arm) |=> (cnt == '0)); // R4
  AST_PERSIST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP); // R6
  AST_PERSIST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && cond && !tick) |=> $stable(cnt)); // R4
endmodule

// File: rtl/chan_guard_judge.sv
module chan_guard_judge (
  input  logic                 short_gnd,
  input  logic                 short_sup,
  input  logic                 short_load,
  input  logic                 vdiff_lo,
  input  logic                 i_over4,
  input  logic                 i_over8,
  input  logic                 imiss_over1,
  input  logic                 imiss_over3,
  input  logic                 vout_lo,
  input  logic                 lo_tier_q,
  input  logic                 imbal_q,
  output logic                 lo_tier_cond,
  output logic                 imbal_raw,
  output logic                 trip,
  output chan_guard_pkg::kind_e kind
);
  import chan_guard_pkg::*;

  logic hi_tier_hit;
  logic any_short;

  assign lo_tier_cond = vdiff_lo && i_over4;
  assign hi_tier_hit  = !vdiff_lo && i_over8;
  assign imbal_raw    = imbal_cond(vout_lo, imiss_over1, imiss_over3);
  assign any_short    = short_gnd || short_sup || short_load;
  assign trip         = any_short || hi_tier_hit || lo_tier_q || imbal_q;
  assign kind         = pick_kind(short_gnd, short_sup, short_load,
                                  hi_tier_hit || lo_tier_q, imbal_q);

  always_comb begin
    AST_TRIP_HAS_KIND: assert (!trip || kind != KIND_NONE); // R7
  end
endmodule

// File: rtl/chan_guard_retry.sv
module chan_guard_retry #(
  parameter int OFF_TICKS = 1600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  host_off,
  input  logic                  trip,
  input  chan_guard_pkg::kind_e kind_in,
  output logic                  run,
  output logic                  load_fault,
  output chan_guard_pkg::kind_e fault_kind
);
  import chan_guard_pkg::*;

  localparam int OCW = (OFF_TICKS > 1) ? $clog2(OFF_TICKS) : 1;
  localparam logic [OCW-1:0] LAST = OCW'(OFF_TICKS - 1);

  guard_st_e      st;
  logic [OCW-1:0] cnt;
  logic           cool_done;

  assign cool_done = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      cnt        <= '0;
      fault_kind <= KIND_NONE;
    end else if (host_off) begin
      st  <= ST_HELD;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_RUN: if (trip) begin
          st         <= ST_COOL;
          cnt        <= '0;
          fault_kind <= kind_in;
        end
        ST_COOL: if (cool_done) begin
          st  <= ST_RUN;
          cnt <= '0;
        end else if (tick) begin
          cnt <= cnt + 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign run        = (st == ST_RUN);
  assign load_fault = (st == ST_COOL);

  AST_COOL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R2
  AST_COOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL && !tick && !host_off) |=> (st == ST_COOL && $stable(cnt))); // R2
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_off |=> (!run && !load_fault)); // R8
endmodule

// File: rtl/chan_guard.sv
module chan_guard #(
  parameter int OFF_TICKS      = 1600,
  parameter int SOA_QUAL_TICKS = 31,
  parameter int SPK_QUAL_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       host_off,
  input  logic       short_gnd,
  input  logic       short_sup,
  input  logic       short_load,
  input  logic       vdiff_lo,
  input  logic       i_over4,
  input  logic       i_over8,
  input  logic       imiss_over1,
  input  logic       imiss_over3,
  input  logic       vout_lo,
  output logic       ch_en,
  output logic       load_fault,
  output logic [2:0] fault_kind
);
  import chan_guard_pkg::*;

  localparam int NQ = 2;
  localparam int QLIM [NQ] = '{SOA_QUAL_TICKS, SPK_QUAL_TICKS};

  logic          run;
  logic          trip;
  kind_e         trip_kind;
  kind_e         kind_q;
  logic [NQ-1:0] q_cond;
  logic [NQ-1:0] q_hit;

  chan_guard_judge u_judge (
    .short_gnd   (short_gnd),
    .short_sup   (short_sup),
    .short_load  (short_load),
    .vdiff_lo    (vdiff_lo),
    .i_over4     (i_over4),
    .i_over8     (i_over8),
    .imiss_over1 (imiss_over1),
    .imiss_over3 (imiss_over3),
    .vout_lo     (vout_lo),
    .lo_tier_q   (q_hit[0]),
    .imbal_q     (q_hit[1]),
    .lo_tier_cond(q_cond[0]),
    .imbal_raw   (q_cond[1]),
    .trip        (trip),
    .kind        (trip_kind)
  );

  for (genvar gi = 0; gi < NQ; gi++) begin : g_persist
    chan_guard_persist #(.LIMIT(QLIM[gi])) u_persist (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (run),
      .tick     (tick),
      .cond     (q_cond[gi]),
      .qualified(q_hit[gi])
    );
  end

  chan_guard_retry #(.OFF_TICKS(OFF_TICKS)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .host_off  (host_off),
    .trip      (trip),
    .kind_in   (trip_kind),
    .run       (run),
    .load_fault(load_fault),
    .fault_kind(kind_q)
  );

  assign ch_en      = run;
  assign fault_kind = kind_q;

  AST_SHORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !host_off && (short_gnd || short_sup || short_load)) |=> !ch_en); // R1
  AST_HI_TIER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && !host_off && !vdiff_lo && i_over8) |=> (!ch_en && fault_kind != 3'd0)); // R5
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fault && $past(load_fault)) |-> $stable(fault_kind)); // R7
  AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_en, load_fault})); // R7
endmodule

// File: tb/chan_guard_tb_top.sv
module chan_guard_tb_top;

  localparam int OFF = 8;
  localparam int SQ  = 5;
  localparam int PQ  = 3;
  localparam int NV  = 37;

  // {flags[8:0] = gnd,sup,across,vdiff_lo,i4,i8,m1,m3,vout_lo ; host ; ncyc ; en ; lf ; kind}
  localparam logic [22:0] VEC [NV] = '{
    {9'b000000000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd0}, // 0  idle R9
    {9'b100000000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd1}, // 1  ground short R1 R7
    {9'b000000000, 1'b0, 8'd6,  1'b0, 1'b1, 3'd1}, // 2  cooling R2
    {9'b000000000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd1}, // 3  last cool edge R2
    {9'b000000000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd1}, // 4  retry, kind held R2 R7
    {9'b011000000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd2}, // 5  priority R7
    {9'b010000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd2}, // 6  retry with short R3
    {9'b010000000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd2}, // 7  re-trip R3
    {9'b000000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd2}, // 8
    {9'b000110000, 1'b0, 8'd5,  1'b1, 1'b0, 3'd2}, // 9  lo tier qualifying R4
    {9'b000110000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd4}, // 10 lo tier trip R4
    {9'b000000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd4}, // 11
    {9'b000110000, 1'b0, 8'd4,  1'b1, 1'b0, 3'd4}, // 12 R4
    {9'b000000000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd4}, // 13 break restarts R4
    {9'b000110000, 1'b0, 8'd5,  1'b1, 1'b0, 3'd4}, // 14 R4
    {9'b000110000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd4}, // 15 R4
    {9'b000000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd4}, // 16
    {9'b000011000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd4}, // 17 hi tier at once R5
    {9'b000000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd4}, // 18
    {9'b000111000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd4}, // 19 i8 at low V no trip R5
    {9'b000000000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd4}, // 20
    {9'b000000101, 1'b0, 8'd3,  1'b1, 1'b0, 3'd4}, // 21 imbalance low V R6
    {9'b000000101, 1'b0, 8'd1,  1'b0, 1'b1, 3'd5}, // 22 R6
    {9'b000000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd5}, // 23
    {9'b000000100, 1'b0, 8'd6,  1'b1, 1'b0, 3'd5}, // 24 1 A at high V ignored R6
    {9'b000000010, 1'b0, 8'd3,  1'b1, 1'b0, 3'd5}, // 25 R6
    {9'b000000010, 1'b0, 8'd1,  1'b0, 1'b1, 3'd5}, // 26 R6
    {9'b000000000, 1'b0, 8'd8,  1'b1, 1'b0, 3'd5}, // 27
    {9'b100000000, 1'b1, 8'd1,  1'b0, 1'b0, 3'd5}, // 28 host overrides R8
    {9'b100000000, 1'b1, 8'd20, 1'b0, 1'b0, 3'd5}, // 29 no retries R8
    {9'b000000000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd5}, // 30 release R8
    {9'b100000000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd1}, // 31 R10
    {9'b000110000, 1'b0, 8'd7,  1'b0, 1'b1, 3'd1}, // 32 flags in cool-down R10
    {9'b000110000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd1}, // 33 retry on time R10
    {9'b000110000, 1'b0, 8'd4,  1'b1, 1'b0, 3'd1}, // 34 count from zero R10
    {9'b000110000, 1'b0, 8'd1,  1'b1, 1'b0, 3'd1}, // 35 R10
    {9'b000110000, 1'b0, 8'd1,  1'b0, 1'b1, 3'd4}  // 36 R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic host_off = 1'b0;
  logic [8:0] flg = '0;
  logic ch_en, load_fault;
  logic [2:0] fault_kind;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  chan_guard #(.OFF_TICKS(OFF), .SOA_QUAL_TICKS(SQ), .SPK_QUAL_TICKS(PQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_off(host_off),
    .short_gnd(flg[8]), .short_sup(flg[7]), .short_load(flg[6]),
    .vdiff_lo(flg[5]), .i_over4(flg[4]), .i_over8(flg[3]),
    .imiss_over1(flg[2]), .imiss_over3(flg[1]), .vout_lo(flg[0]),
    .ch_en(ch_en), .load_fault(load_fault), .fault_kind(fault_kind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input int en, input int lf, input int k);
    chk({tag, " ch_en"}, int'(ch_en), en);
    chk({tag, " load_fault"}, int'(load_fault), lf);
    chk({tag, " fault_kind"}, int'(fault_kind), k);
  endtask

  initial begin
    @(negedge clk);
    edges(2);
    chk_out("R9 in reset", 1, 0, 0);
    rst_n = 1'b1;
    edges(1);
    chk_out("R9 after reset", 1, 0, 0);

    for (int i = 0; i < NV; i++) begin
      flg      = VEC[i][22:14];
      host_off = VEC[i][13];
      edges(int'(VEC[i][12:5]));
      chk_out($sformatf("vector %0d", i), int'(VEC[i][4]), int'(VEC[i][3]), int'(VEC[i][2:0]));
    end
    flg = '0;
    edges(OFF + 1);
    chk("R2 settle", int'(ch_en), 1);

    // R2: cool-down advances only on ticked edges
    flg = 9'b100000000;
    edges(1);
    flg = '0;
    tick = 1'b0;
    edges(30);
    chk("R2 no tick holds off", int'(ch_en), 0);
    tick = 1'b1;
    edges(OFF - 1);
    chk("R2 one tick short", int'(ch_en), 0);
    edges(1);
    chk("R2 retry after ticks", int'(ch_en), 1);

    // R4: qualification does not advance without tick
    tick = 1'b0;
    flg = 9'b000110000;
    edges(20);
    chk("R4 no tick no trip", int'(ch_en), 1);
    tick = 1'b1;
    edges(SQ);
    chk("R4 ticked count", int'(ch_en), 1);
    edges(1);
    chk("R4 ticked trip", int'(ch_en), 0);
    flg = '0;
    edges(OFF);

    // R8: release with short present re-trips
    host_off = 1'b1;
    flg = 9'b001000000;
    edges(3);
    chk("R8 held", int'(ch_en), 0);
    host_off = 1'b0;
    edges(1);
    chk("R8 released", int'(ch_en), 1);
    edges(1);
    chk_out("R8 re-trip across", 0, 1, 3);
    flg = '0;

    // R9: reset in mid cool-down
    rst_n = 1'b0;
    edges(1);
    chk_out("R9 mid-run reset", 1, 0, 0);
    rst_n = 1'b1;
    edges(1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule